// File: doc/BRIEF.md
# PoE Port Lifecycle Controller

This block sequences one powered Ethernet output from an unpowered, searching condition to steady delivery and back again. It reacts to a small set of qualified flags from the analog front end, the power allocator and the protection comparators. It never measures anything itself. From those flags it decides whether the output switch is closed and whether the inrush limiter is engaged. It also reports the port's current phase, the cause of the most recent trip, how many overcurrent retries have been consumed, and whether the port has been locked out.

Recovery from faults is bounded. An overcurrent opens the port at once, and the port then waits out a programmable cooldown before it searches again. A programmable number of such retries is allowed before the port latches off, and only an explicit clear input releases it. Overtemperature is handled in two steps: it first raises a derate request while the port stays powered, and it removes power only if the condition persists. Surge events are counted and recorded but never change the port's phase. A budget refusal keeps the port unpowered without consuming a retry.

Top module: `pse_port_lifecycle`

## Requirements
- R1: After reset the port is in the searching phase (state code 0) with the output off, inrush limit off, derate off, fault code 0 (none), retry count 0, surge count 0, port class 0 and lockout clear.
- R2: State codes are 0 search, 1 classify, 2 await budget, 3 inrush ramp, 4 maintain, 5 monitor, 6 cooldown, 7 lockout. The port leaves search for classify only on a cycle where signature-valid is high, and otherwise it stays in search.
- R3: In classify the port stays unpowered until class-valid is seen. Class code 1, 2 or 3 is latched on the port class output and moves the port to state 2. Class code 0 returns the port to state 0 with fault code 6.
- R4: In state 2 the output stays off until a budget grant arrives. A budget deny without a grant holds the port in state 2, sets fault code 5 and leaves the retry count unchanged.
- R5: A grant moves the port to state 3. There the output is on with the inrush limit engaged for exactly RAMP_CYCLES cycles, after which the port enters state 4 with the limit released.
- R6: State 4 moves to state 5 on a cycle with the maintain signature present. In states 4 and 5, MPS_LOSS_CYCLES consecutive cycles without it return the port to state 0 with the output off and fault code 4.
- R7: An overcurrent flag in states 3, 4 or 5 opens the output on the next cycle, sets fault code 1 and increments the retry count.
- R8: The cooldown state lasts cooldownCycles+1 cycles and then returns to state 0.
- R9: An overcurrent trip taken while the retry count already equals or exceeds maxRetries enters state 7 with lockout high. The port stays there regardless of the other inputs until clrLockout, which clears lockout and the retry count and returns to state 0.
- R10: STABLE_CYCLES consecutive cycles in state 5 clear the retry count to 0.
- R11: While the port is powered, an overtemperature flag raises derate on the next cycle and the output stays on. Derate drops after OT_HYST_CYCLES consecutive cycles without the flag. OT_SHUT_CYCLES further flagged cycles while derate is high send the port to state 6 with fault code 2, derate off and the retry count unchanged.
- R12: A surge flag increments a saturating surge count and sets fault code 3, and it does not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sigValid | input | 1 | Valid detection signature seen |
| classValid | input | 1 | Class result ready |
| classCode | input | 2 | Class result: 0 invalid, 1/2/3 power tiers |
| budgetGrant | input | 1 | Allocator grants power |
| budgetDeny | input | 1 | Allocator refuses power |
| mpsPresent | input | 1 | Maintain-power signature present |
| ocTrip | input | 1 | Overcurrent or short flag |
| otTrip | input | 1 | Overtemperature flag |
| surgeTrip | input | 1 | Surge event flag |
| clrLockout | input | 1 | Explicit lockout release |
| cooldownCycles | input | CD_W | Cooldown length minus one |
| maxRetries | input | RT_W | Overcurrent retries allowed before lockout |
| portEn | output | 1 | Output power switch closed |
| inrushLimit | output | 1 | Inrush current limit engaged |
| derate | output | 1 | Thermal derate request |
| stateCode | output | 3 | Current phase |
| faultCode | output | 3 | Cause of latest trip or refusal |
| portClass | output | 2 | Latched class result |
| retryCnt | output | RT_W | Overcurrent retries consumed |
| lockout | output | 1 | Port latched off |
| surgeCnt | output | SURGE_W | Saturating surge event count |

## Verification
The embedded checks assume that cooldownCycles and maxRetries are held steady while a port is in use. They also assume that clrLockout is a deliberate pulse rather than a level held across normal operation. The stimulus sets both programming inputs once during reset and raises the release input for exactly one cycle, only while the port is locked out. Flags from the front end are applied as clean one-cycle or multi-cycle levels at the falling edge, so every input is stable at each rising edge. Budget grant and deny are never raised together.

// File: rtl/pse_pkg.sv
package pse_pkg;

  typedef enum logic [2:0] {
    ST_SEARCH   = 3'd0,
    ST_CLASSIFY = 3'd1,
    ST_AWAIT    = 3'd2,
    ST_RAMP     = 3'd3,
    ST_MAINTAIN = 3'd4,
    ST_MONITOR  = 3'd5,
    ST_COOLDOWN = 3'd6,
    ST_LOCKED   = 3'd7
  } portState_e;

  typedef enum logic [2:0] {
    FC_NONE    = 3'd0,
    FC_OVERCUR = 3'd1,
    FC_OVERTMP = 3'd2,
    FC_SURGE   = 3'd3,
    FC_MPSLOST = 3'd4,
    FC_BUDGET  = 3'd5,
    FC_BADCLS  = 3'd6
  } faultCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchClass;
    logic classBad;
    logic budgetDeny;
    logic rampTick;
    logic mpsWatch;
    logic otWatch;
    logic stableTick;
    logic tripOc;
    logic tripOt;
    logic mpsLost;
    logic leavePower;
    logic enterFault;
    logic coolTick;
    logic clrRetry;
  } pseCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic rampDone;
    logic mpsLossHit;
    logic otShutHit;
    logic coolDone;
    logic retryAtLimit;
  } pseStat_t;

endpackage

// File: rtl/pse_run_cnt.sv
// Counts consecutive cycles of a run condition; hit on the LIMIT-th one.
module pse_run_cnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic hit
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt != TOP)  cnt <= cnt + 1'b1;
  end

  assign hit = run && (cnt == TOP);

  // a hit needs an unbroken run behind it (LIMIT>1 case)
  // R6
  run_contiguous_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit && LIMIT > 1) |-> $past(run));

endmodule

// File: rtl/pse_port_dp.sv
module pse_port_dp
  import pse_pkg::*;
#(
  parameter int RAMP_CYCLES     = 4,
  parameter int MPS_LOSS_CYCLES = 3,
  parameter int OT_SHUT_CYCLES  = 5,
  parameter int OT_HYST_CYCLES  = 4,
  parameter int STABLE_CYCLES   = 16,
  parameter int CD_W            = 8,
  parameter int RT_W            = 3,
  parameter int SURGE_W         = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  pseCtl_t            ctl,
  input  logic [1:0]         classCode,
  input  logic               mpsPresent,
  input  logic               otTrip,
  input  logic               surgeTrip,
  input  logic [CD_W-1:0]    cooldownCycles,
  input  logic [RT_W-1:0]    maxRetries,
  output pseStat_t           stat,
  output logic               derate,
  output logic [2:0]         faultCode,
  output logic [1:0]         portClass,
  output logic [RT_W-1:0]    retryCnt,
  output logic [SURGE_W-1:0] surgeCnt
);

  localparam logic [RT_W-1:0]    RETRY_MAX = '1;
  localparam logic [SURGE_W-1:0] SURGE_MAX = '1;

  logic derateQ;
  logic hystHit;
  logic stableHit;
  logic [CD_W-1:0] coolCnt;

  // windowed run counters
  pse_run_cnt #(.LIMIT(RAMP_CYCLES)) rampWin_i (
    .clk(clk), .rstN(rstN), .run(ctl.rampTick), .hit(stat.rampDone));

  pse_run_cnt #(.LIMIT(MPS_LOSS_CYCLES)) mpsWin_i (
    .clk(clk), .rstN(rstN), .run(ctl.mpsWatch && !mpsPresent),
    .hit(stat.mpsLossHit));

  pse_run_cnt #(.LIMIT(OT_SHUT_CYCLES)) otHotWin_i (
    .clk(clk), .rstN(rstN), .run(ctl.otWatch && derateQ && otTrip),
    .hit(stat.otShutHit));

  pse_run_cnt #(.LIMIT(OT_HYST_CYCLES)) otCoolWin_i (
    .clk(clk), .rstN(rstN), .run(ctl.otWatch && derateQ && !otTrip),
    .hit(hystHit));

  pse_run_cnt #(.LIMIT(STABLE_CYCLES)) stableWin_i (
    .clk(clk), .rstN(rstN), .run(ctl.stableTick), .hit(stableHit));

  // thermal derate with hysteresis
  always_ff @(posedge clk) begin
    if (!rstN)                            derateQ <= 1'b0;
    else if (!ctl.otWatch || ctl.leavePower) derateQ <= 1'b0;
    else if (otTrip)                      derateQ <= 1'b1;
    else if (hystHit)                     derateQ <= 1'b0;
  end
  assign derate = derateQ;

  // cooldown timer
  always_ff @(posedge clk) begin
    if (!rstN)                              coolCnt <= '0;
    else if (ctl.enterFault)                coolCnt <= cooldownCycles;
    else if (ctl.coolTick && coolCnt != 0)  coolCnt <= coolCnt - 1'b1;
  end
  assign stat.coolDone = (coolCnt == '0);

  // retry accounting
  always_ff @(posedge clk) begin
    if (!rstN)              retryCnt <= '0;
    else if (ctl.clrRetry)  retryCnt <= '0;
    else if (ctl.tripOc)    retryCnt <= (retryCnt == RETRY_MAX) ? retryCnt : retryCnt + 1'b1;
    else if (stableHit)     retryCnt <= '0;
  end
  assign stat.retryAtLimit = (retryCnt >= maxRetries);

  // latched cause of the latest event
  always_ff @(posedge clk) begin
    if (!rstN)               faultCode <= FC_NONE;
    else if (ctl.tripOc)     faultCode <= FC_OVERCUR;
    else if (ctl.tripOt)     faultCode <= FC_OVERTMP;
    else if (ctl.mpsLost)    faultCode <= FC_MPSLOST;
    else if (ctl.budgetDeny) faultCode <= FC_BUDGET;
    else if (ctl.classBad)   faultCode <= FC_BADCLS;
    else if (surgeTrip)      faultCode <= FC_SURGE;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                surgeCnt <= '0;
    else if (surgeTrip && surgeCnt != SURGE_MAX) surgeCnt <= surgeCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               portClass <= 2'd0;
    else if (ctl.latchClass) portClass <= classCode;
  end

  // R4
  budget_no_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.budgetDeny |=> $stable(retryCnt));

  // R11
  derate_hyst_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(derateQ) && $past(ctl.otWatch) && ctl.otWatch) |-> !$past(otTrip));

  // R12
  surge_count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !surgeTrip |=> $stable(surgeCnt));

endmodule

// File: rtl/pse_port_fsm.sv
module pse_port_fsm
  import pse_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sigValid,
  input  logic       classValid,
  input  logic [1:0] classCode,
  input  logic       budgetGrant,
  input  logic       budgetDeny,
  input  logic       mpsPresent,
  input  logic       ocTrip,
  input  logic       otTrip,
  input  logic       surgeTrip,
  input  logic       clrLockout,
  input  pseStat_t   stat,
  output portState_e state,
  output pseCtl_t    ctl
);

  portState_e nxt;
  logic powered;

  assign powered = (state == ST_RAMP) || (state == ST_MAINTAIN) || (state == ST_MONITOR);

  always_comb begin
    nxt = state;
    ctl = '0;
    ctl.otWatch  = powered;
    ctl.mpsWatch = (state == ST_MAINTAIN) || (state == ST_MONITOR);
    unique case (state)
      ST_SEARCH:   if (sigValid) nxt = ST_CLASSIFY;
      ST_CLASSIFY: if (classValid) begin
                     if (classCode == 2'd0) begin
                       ctl.classBad = 1'b1;
                       nxt = ST_SEARCH;
                     end else begin
                       ctl.latchClass = 1'b1;
                       nxt = ST_AWAIT;
                     end
                   end
      ST_AWAIT:    if (budgetGrant) nxt = ST_RAMP;
                   else if (budgetDeny) ctl.budgetDeny = 1'b1;
      ST_RAMP:     begin
                     ctl.rampTick = 1'b1;
                     if (stat.rampDone) nxt = ST_MAINTAIN;
                   end
      ST_MAINTAIN: if (mpsPresent) nxt = ST_MONITOR;
      ST_MONITOR:  ctl.stableTick = 1'b1;
      ST_COOLDOWN: begin
                     ctl.coolTick = 1'b1;
                     if (stat.coolDone) nxt = ST_SEARCH;
                   end
      ST_LOCKED:   if (clrLockout) begin
                     ctl.clrRetry = 1'b1;
                     nxt = ST_SEARCH;
                   end
      default:     nxt = ST_SEARCH;
    endcase

    // protection overrides while powered
    if (powered) begin
      if (ocTrip) begin
        ctl.tripOc     = 1'b1;
        ctl.leavePower = 1'b1;
        ctl.enterFault = 1'b1;
        ctl.stableTick = 1'b0;
        nxt = stat.retryAtLimit ? ST_LOCKED : ST_COOLDOWN;
      end else if (stat.otShutHit) begin
        ctl.tripOt     = 1'b1;
        ctl.leavePower = 1'b1;
        ctl.enterFault = 1'b1;
        nxt = ST_COOLDOWN;
      end else if (stat.mpsLossHit) begin
        ctl.mpsLost    = 1'b1;
        ctl.leavePower = 1'b1;
        nxt = ST_SEARCH;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_SEARCH;
    else       state <= nxt;
  end

  // R2
  search_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEARCH) |=> (state == ST_SEARCH || state == ST_CLASSIFY));

  // R4
  await_needs_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_AWAIT && !budgetGrant) |=> (state == ST_AWAIT));

  // R7
  oc_cuts_power_chk: assert property (@(posedge clk) disable iff (!rstN)
    (powered && ocTrip) |=> (state == ST_COOLDOWN || state == ST_LOCKED));

  // R9
  lockout_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCKED && !clrLockout) |=> (state == ST_LOCKED));

  // R12
  surge_no_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MONITOR && surgeTrip && !ocTrip && !otTrip && mpsPresent)
      |=> (state == ST_MONITOR));

endmodule

// File: rtl/pse_port_lifecycle.sv
module pse_port_lifecycle
  import pse_pkg::*;
#(
  parameter int RAMP_CYCLES     = 4,
  parameter int MPS_LOSS_CYCLES = 3,
  parameter int OT_SHUT_CYCLES  = 5,
  parameter int OT_HYST_CYCLES  = 4,
  parameter int STABLE_CYCLES   = 16,
  parameter int CD_W            = 8,
  parameter int RT_W            = 3,
  parameter int SURGE_W         = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sigValid,
  input  logic               classValid,
  input  logic [1:0]         classCode,
  input  logic               budgetGrant,
  input  logic               budgetDeny,
  input  logic               mpsPresent,
  input  logic               ocTrip,
  input  logic               otTrip,
  input  logic               surgeTrip,
  input  logic               clrLockout,
  input  logic [CD_W-1:0]    cooldownCycles,
  input  logic [RT_W-1:0]    maxRetries,
  output logic               portEn,
  output logic               inrushLimit,
  output logic               derate,
  output logic [2:0]         stateCode,
  output logic [2:0]         faultCode,
  output logic [1:0]         portClass,
  output logic [RT_W-1:0]    retryCnt,
  output logic               lockout,
  output logic [SURGE_W-1:0] surgeCnt
);

  portState_e state;
  pseCtl_t    ctl;
  pseStat_t   stat;

  pse_port_fsm fsm_i (
    .clk(clk), .rstN(rstN), .sigValid(sigValid), .classValid(classValid),
    .classCode(classCode), .budgetGrant(budgetGrant), .budgetDeny(budgetDeny),
    .mpsPresent(mpsPresent), .ocTrip(ocTrip), .otTrip(otTrip),
    .surgeTrip(surgeTrip), .clrLockout(clrLockout), .stat(stat),
    .state(state), .ctl(ctl));

  pse_port_dp #(
    .RAMP_CYCLES(RAMP_CYCLES), .MPS_LOSS_CYCLES(MPS_LOSS_CYCLES),
    .OT_SHUT_CYCLES(OT_SHUT_CYCLES), .OT_HYST_CYCLES(OT_HYST_CYCLES),
    .STABLE_CYCLES(STABLE_CYCLES), .CD_W(CD_W), .RT_W(RT_W), .SURGE_W(SURGE_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .classCode(classCode),
    .mpsPresent(mpsPresent), .otTrip(otTrip), .surgeTrip(surgeTrip),
    .cooldownCycles(cooldownCycles), .maxRetries(maxRetries), .stat(stat),
    .derate(derate), .faultCode(faultCode), .portClass(portClass),
    .retryCnt(retryCnt), .surgeCnt(surgeCnt));

  assign stateCode   = state;
  assign portEn      = (state == ST_RAMP) || (state == ST_MAINTAIN) || (state == ST_MONITOR);
  assign inrushLimit = (state == ST_RAMP);
  assign lockout     = (state == ST_LOCKED);

  // R9
  locked_is_dark_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockout) |-> (!portEn && $past(ocTrip)));

endmodule

// File: tb/pse_port_lifecycle_tb_top.sv
`timescale 1ns/1ps
module pse_port_lifecycle_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sigValid = 0, classValid = 0, budgetGrant = 0, budgetDeny = 0;
  logic mpsPresent = 0, ocTrip = 0, otTrip = 0, surgeTrip = 0, clrLockout = 0;
  logic [1:0] classCode = 0;
  logic [7:0] cooldownCycles = 8'd3;
  logic [2:0] maxRetries = 3'd2;
  logic portEn, inrushLimit, derate, lockout;
  logic [2:0] stateCode, faultCode, retryCnt;
  logic [1:0] portClass;
  logic [7:0] surgeCnt;

  always #10 clk = ~clk;

  pse_port_lifecycle dut_i (
    .clk(clk), .rstN(rstN), .sigValid(sigValid), .classValid(classValid),
    .classCode(classCode), .budgetGrant(budgetGrant), .budgetDeny(budgetDeny),
    .mpsPresent(mpsPresent), .ocTrip(ocTrip), .otTrip(otTrip),
    .surgeTrip(surgeTrip), .clrLockout(clrLockout),
    .cooldownCycles(cooldownCycles), .maxRetries(maxRetries),
    .portEn(portEn), .inrushLimit(inrushLimit), .derate(derate),
    .stateCode(stateCode), .faultCode(faultCode), .portClass(portClass),
    .retryCnt(retryCnt), .lockout(lockout), .surgeCnt(surgeCnt));

  typedef struct {
    string      tag;
    int         due;
    logic [2:0] st;
    logic [2:0] fc;
    logic [2:0] rc;
    logic [7:0] sc;
    logic       dr;
    logic [1:0] cls;
  } expItem_t;

  expItem_t expQ[$];
  int cyc = 0;
  int checkCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  // running expectations maintained by the stimulus
  logic [2:0] eFc = 0, eRc = 0;
  logic [7:0] eSc = 0;
  logic       eDr = 0;
  logic [1:0] eCls = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // driver side: push an expectation for the current cycle
  task automatic chk(input string tag, input logic [2:0] st);
    expItem_t it;
    it.tag = tag; it.due = cyc; it.st = st; it.fc = eFc; it.rc = eRc;
    it.sc = eSc; it.dr = eDr; it.cls = eCls;
    expQ.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop and compare
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (expQ.size() > 0 && expQ[0].due <= cyc) begin
        expItem_t it;
        logic expEn, expInr, expLk;
        it = expQ.pop_front();
        expEn  = (it.st == 3'd3) || (it.st == 3'd4) || (it.st == 3'd5);
        expInr = (it.st == 3'd3);
        expLk  = (it.st == 3'd7);
        checkCnt++;
        if (stateCode !== it.st || faultCode !== it.fc || retryCnt !== it.rc ||
            surgeCnt !== it.sc || derate !== it.dr || portClass !== it.cls ||
            portEn !== expEn || inrushLimit !== expInr || lockout !== expLk) begin
          failCnt++;
          $display("FAIL %s: act st=%0d fc=%0d rc=%0d sc=%0d dr=%0b cls=%0d en=%0b inr=%0b lk=%0b exp st=%0d fc=%0d rc=%0d sc=%0d dr=%0b cls=%0d en=%0b inr=%0b lk=%0b",
                   it.tag, stateCode, faultCode, retryCnt, surgeCnt, derate, portClass,
                   portEn, inrushLimit, lockout, it.st, it.fc, it.rc, it.sc, it.dr,
                   it.cls, expEn, expInr, expLk);
        end
      end
    end
  end

  // search -> monitor with a valid class
  task automatic bringUp(input logic [1:0] cls);
    sigValid = 1; tick(1); sigValid = 0;
    classValid = 1; classCode = cls; tick(1); classValid = 0;
    eCls = cls;
    budgetGrant = 1; tick(1); budgetGrant = 0;
    tick(RAMP_LEN);
    mpsPresent = 1; tick(1);
  endtask

  localparam int RAMP_LEN = 4;

  initial begin
    tick(3);
    rstN = 1;
    tick(1);
    chk("R1 reset state", 3'd0);

    tick(3);
    chk("R2 search holds without signature", 3'd0);
    sigValid = 1; tick(1); sigValid = 0;
    chk("R2 signature enters classify", 3'd1);
    tick(2);
    chk("R3 classify waits for result", 3'd1);
    classValid = 1; classCode = 2'd0; tick(1); classValid = 0;
    eFc = 3'd6;
    chk("R3 invalid class back to search", 3'd0);

    sigValid = 1; tick(1); sigValid = 0;
    classValid = 1; classCode = 2'd3; tick(1); classValid = 0;
    eCls = 2'd3;
    chk("R3 class latched, awaiting budget", 3'd2);
    budgetDeny = 1; tick(3); budgetDeny = 0;
    eFc = 3'd5;
    chk("R4 deny holds unpowered, no retry", 3'd2);
    tick(2);
    chk("R4 no grant stays off", 3'd2);

    budgetGrant = 1; tick(1); budgetGrant = 0;
    chk("R5 grant starts ramp", 3'd3);
    tick(RAMP_LEN - 1);
    chk("R5 ramp last cycle", 3'd3);
    tick(1);
    chk("R5 ramp done to maintain", 3'd4);
    tick(2);
    chk("R6 maintain tolerates short absence", 3'd4);
    mpsPresent = 1; tick(1);
    chk("R6 signature moves to monitor", 3'd5);

    surgeTrip = 1; tick(1); surgeTrip = 0;
    eSc = 1; eFc = 3'd3;
    chk("R12 surge counted, state kept", 3'd5);
    surgeTrip = 1; tick(2); surgeTrip = 0;
    eSc = 3;
    chk("R12 two more surges", 3'd5);

    mpsPresent = 0; tick(2);
    chk("R6 monitor before loss window", 3'd5);
    tick(1);
    eFc = 3'd4;
    chk("R6 signature lost to search", 3'd0);

    // thermal
    bringUp(2'd1);
    chk("R11 powered before heat", 3'd5);
    otTrip = 1; tick(1);
    eDr = 1;
    chk("R11 derate first, power kept", 3'd5);
    otTrip = 0; tick(3);
    chk("R11 derate held by hysteresis", 3'd5);
    tick(1);
    eDr = 0;
    chk("R11 derate released", 3'd5);
    otTrip = 1; tick(1);
    eDr = 1;
    chk("R11 derate again", 3'd5);
    tick(4);
    chk("R11 still powered while derated", 3'd5);
    tick(1);
    eDr = 0; eFc = 3'd2;
    chk("R11 persistent heat shuts down", 3'd6);
    otTrip = 0; tick(4);
    chk("R8 cooldown after thermal", 3'd0);

    // overcurrent retries and lockout
    bringUp(2'd2);
    ocTrip = 1; tick(1); ocTrip = 0;
    eFc = 3'd1; eRc = 1;
    chk("R7 overcurrent trips", 3'd6);
    tick(3);
    chk("R8 cooldown still running", 3'd6);
    tick(1);
    chk("R8 cooldown ends in search", 3'd0);
    bringUp(2'd2);
    ocTrip = 1; tick(1); ocTrip = 0;
    eRc = 2;
    chk("R7 second trip", 3'd6);
    tick(4);
    bringUp(2'd2);
    ocTrip = 1; tick(1); ocTrip = 0;
    eRc = 3;
    chk("R9 third trip locks out", 3'd7);
    sigValid = 1; tick(5); sigValid = 0;
    chk("R9 lockout ignores signature", 3'd7);
    clrLockout = 1; tick(1); clrLockout = 0;
    eRc = 0;
    chk("R9 clear releases lockout", 3'd0);

    // retry decay in monitor
    bringUp(2'd3);
    ocTrip = 1; tick(1); ocTrip = 0;
    eRc = 1;
    chk("R7 trip before stable window", 3'd6);
    tick(4);
    bringUp(2'd3);
    tick(15);
    chk("R10 retry kept before window", 3'd5);
    tick(1);
    eRc = 0;
    chk("R10 retry cleared after stable window", 3'd5);

    tick(3);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: act running exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

endmodule